// File: doc/BRIEF.md
# Trap entry and return unit

A purely combinational execution stage for a 64-bit core. It implements the two trap-related operations: the system call, which records where to resume and the interrupted machine state, and the return from interrupt, which rebuilds the machine state register (MSR) from the saved copy and computes where to continue fetching. Decode, other exception kinds and pipeline flow control stay outside this stage.

Bit positions follow a most-significant-first convention: position 0 is port bit 63, and position k is port bit 63-k. The MSR fields in use are hypervisor at position 3, transaction state at 29 to 31, external-interrupt enable at 48, problem state at 49, machine-check enable at 51, instruction relocate at 58 and data relocate at 59.

Every data output is computed on every cycle from the inputs. The valid flags, derived from the operation code, tell the surrounding pipeline which results to write back. An opaque context tag travels alongside the operation unchanged.

Top module: `trap_unit`

## Requirements
- R1: `op_i` encodes 2'b01 as system call and 2'b10 as return from interrupt; all other codes are idle. A system call raises `srr0_vld_o` and `srr1_vld_o` only. A return raises `msr_vld_o` and `nia_vld_o` only. Idle raises no valid flag.
- R2: `srr0_o` equals `cia_i + 4`, modulo 2^64.
- R3: `srr1_o` positions 33 to 36 and 42 to 47 are zero.
- R4: `srr1_o` positions 0 to 32, 37 to 41 and 48 to 63 equal the same positions of `msr_i`.
- R5: `msr_o` position 3 (hypervisor) is the AND of `srr1_i` position 3 and `msr_i` position 3.
- R6: `msr_o` positions 48, 58 and 59 each equal the same position of `srr1_i` ORed with `srr1_i` position 49 (problem state).
- R7: `msr_o` positions 0 to 2, 4 to 28, 32, 37 to 41, 49 to 50, 52 to 57 and 60 to 63 equal the same positions of `srr1_i`.
- R8: `msr_o` position 51 (machine-check enable) equals `srr1_i` position 51 when `msr_i` position 3 is set, and `msr_i` position 51 otherwise.
- R9: `msr_o` positions 29 to 31 (transaction state) equal those of `srr1_i` for every current value of that field in `msr_i`, including 0b000 and 0b010.
- R10: `msr_o` positions 33 to 36 and 42 to 47 are zero.
- R11: `nia_o` equals `srr0_i` with port bits 1 and 0 cleared.
- R12: `ctx_o` equals `ctx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation code (01 system call, 10 return, else idle) |
| ctx_i | input | CTX_W | Context tag in |
| cia_i | input | 64 | Current instruction address |
| msr_i | input | 64 | Current machine state |
| srr0_i | input | 64 | Saved resume address |
| srr1_i | input | 64 | Saved machine state |
| srr0_o | output | 64 | New saved resume address |
| srr0_vld_o | output | 1 | Write enable for `srr0_o` |
| srr1_o | output | 64 | New saved machine state |
| srr1_vld_o | output | 1 | Write enable for `srr1_o` |
| msr_o | output | 64 | Restored machine state |
| msr_vld_o | output | 1 | Write enable for `msr_o` |
| nia_o | output | 64 | Next instruction address after return |
| nia_vld_o | output | 1 | Write enable for `nia_o` |
| ctx_o | output | CTX_W | Context tag out |

## Verification
The checker assumes that `op_i` and the data inputs are stable between clock edges. It also relies on the stage having no state: each immediate check relates only the values present at the same instant. The bench drives every input just after a rising edge and compares just before the next edge. In that way each comparison sees settled values. It holds each stimulus for one clock and mixes directed corner cases with pseudo-random words. The directed cases cover address wrap, every hypervisor and problem-state combination, and both special transaction-state codes.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN = 64;
  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_SC   = 2'b01,
    OP_RFI  = 2'b10
  } trap_op_e;

  // msb-first position -> port bit index
  function automatic int ix(int pos);
    return XLEN - 1 - pos;
  endfunction

  function automatic word_t span(int first, int last);
    word_t m;
    m = '0;
    for (int p = first; p <= last; p++) m[XLEN-1-p] = 1'b1;
    return m;
  endfunction

  localparam int P_HV = 3;
  localparam int P_EE = 48;
  localparam int P_PR = 49;
  localparam int P_ME = 51;
  localparam int P_IR = 58;
  localparam int P_DR = 59;

  localparam word_t SC_KEEP  = span(0, 32) | span(37, 41) | span(48, 63);
  localparam word_t RFI_COPY = span(0, 2) | span(4, 28) | span(32, 32) | span(37, 41)
                             | span(49, 50) | span(52, 57) | span(60, 63);
  localparam word_t TS_MASK  = span(29, 31);
  localparam word_t RSV_MASK = span(33, 36) | span(42, 47);
endpackage

// File: rtl/trap_sc_unit.sv
module trap_sc_unit
  import trap_pkg::*;
(
  input  word_t cia_i,
  input  word_t msr_i,
  output word_t srr0_o,
  output word_t srr1_o
);
  localparam word_t STEP = word_t'(4);

  assign srr0_o = cia_i + STEP;
  assign srr1_o = msr_i & SC_KEEP;
endmodule

// File: rtl/trap_rfi_unit.sv
module trap_rfi_unit
  import trap_pkg::*;
(
  input  word_t srr0_i,
  input  word_t srr1_i,
  input  logic  cur_hv_i,
  input  logic  cur_me_i,
  output word_t msr_o,
  output word_t nia_o
);
  localparam int N_FORCE = 3;
  localparam int FORCE_POS [N_FORCE] = '{P_EE, P_IR, P_DR};

  logic  pr;
  word_t msr_n;
  logic  unused_bits;

  assign pr          = srr1_i[ix(P_PR)];
  assign unused_bits = ^{srr0_i[1:0], srr1_i & RSV_MASK};

  always_comb begin
    // reserved positions stay zero by starting from the masks
    msr_n = srr1_i & (RFI_COPY | TS_MASK);
    msr_n[ix(P_HV)] = srr1_i[ix(P_HV)] & cur_hv_i;
    for (int k = 0; k < N_FORCE; k++)
      msr_n[ix(FORCE_POS[k])] = srr1_i[ix(FORCE_POS[k])] | pr;
    msr_n[ix(P_ME)] = cur_hv_i ? srr1_i[ix(P_ME)] : cur_me_i;
  end

  assign msr_o = msr_n;
  assign nia_o = {srr0_i[XLEN-1:2], 2'b00};
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int CTX_W = 2
) (
  input  logic [1:0]       op_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [63:0]      cia_i,
  input  logic [63:0]      msr_i,
  input  logic [63:0]      srr0_i,
  input  logic [63:0]      srr1_i,
  output logic [63:0]      srr0_o,
  output logic             srr0_vld_o,
  output logic [63:0]      srr1_o,
  output logic             srr1_vld_o,
  output logic [63:0]      msr_o,
  output logic             msr_vld_o,
  output logic [63:0]      nia_o,
  output logic             nia_vld_o,
  output logic [CTX_W-1:0] ctx_o
);
  logic is_sc, is_rfi;

  assign is_sc  = (op_i == OP_SC);
  assign is_rfi = (op_i == OP_RFI);

  trap_sc_unit u_sc (
    .cia_i  (cia_i),
    .msr_i  (msr_i),
    .srr0_o (srr0_o),
    .srr1_o (srr1_o)
  );

  trap_rfi_unit u_rfi (
    .srr0_i   (srr0_i),
    .srr1_i   (srr1_i),
    .cur_hv_i (msr_i[ix(P_HV)]),
    .cur_me_i (msr_i[ix(P_ME)]),
    .msr_o    (msr_o),
    .nia_o    (nia_o)
  );

  assign srr0_vld_o = is_sc;
  assign srr1_vld_o = is_sc;
  assign msr_vld_o  = is_rfi;
  assign nia_vld_o  = is_rfi;
  assign ctx_o      = ctx_i;
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk
  import trap_pkg::*;
#(
  parameter int CTX_W = 2
) (
  input logic [1:0]       op_i,
  input logic [CTX_W-1:0] ctx_i,
  input logic [63:0]      cia_i,
  input logic [63:0]      msr_i,
  input logic [63:0]      srr0_i,
  input logic [63:0]      srr1_i,
  input logic [63:0]      srr0_o,
  input logic             srr0_vld_o,
  input logic [63:0]      srr1_o,
  input logic             srr1_vld_o,
  input logic [63:0]      msr_o,
  input logic             msr_vld_o,
  input logic [63:0]      nia_o,
  input logic             nia_vld_o,
  input logic [CTX_W-1:0] ctx_o
);
  always_comb begin
    AST_WB_EXCLUSIVE: assert ($onehot0({srr0_vld_o, msr_vld_o}))
      else $error("two result groups valid");                            // R1
    AST_SRR_PAIR: assert (srr0_vld_o == srr1_vld_o)
      else $error("srr valids differ");                                 // R1
    AST_IDLE_QUIET: assert (op_i != 2'b00 || !(srr0_vld_o | msr_vld_o | nia_vld_o))
      else $error("valid while idle");                                  // R1
    AST_SRR0_STEP: assert (srr0_o - cia_i == 64'd4)
      else $error("srr0 not cia+4");                                    // R2
    AST_SRR1_RSV_ZERO: assert ((srr1_o & RSV_MASK) == '0)
      else $error("srr1 reserved set");                                 // R3
    AST_HV_NO_RAISE: assert (msr_i[ix(P_HV)] || !msr_o[ix(P_HV)])
      else $error("hv raised by return");                               // R5
    AST_PR_FORCES: assert (!srr1_i[ix(P_PR)] ||
                           (msr_o[ix(P_EE)] && msr_o[ix(P_IR)] && msr_o[ix(P_DR)]))
      else $error("problem state did not force enables");               // R6
    AST_ME_HELD: assert (msr_i[ix(P_HV)] || msr_o[ix(P_ME)] == msr_i[ix(P_ME)])
      else $error("me changed without hv");                             // R8
    AST_MSR_RSV_ZERO: assert ((msr_o & RSV_MASK) == '0)
      else $error("msr reserved set");                                  // R10
    AST_NIA_ALIGN: assert (nia_o[1:0] == 2'b00 && nia_o[63:2] == srr0_i[63:2])
      else $error("nia misaligned");                                    // R11
    AST_CTX_PASS: assert (ctx_o == ctx_i)
      else $error("ctx altered");                                       // R12
  end
endmodule

bind trap_unit trap_unit_chk #(.CTX_W(CTX_W)) u_chk (.*);

// File: tb/tb_trap_unit.sv
module tb_trap_unit;
  localparam int CTX_W = 2;
  localparam time TCK = 8ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic [1:0]       op_i = 2'b00;
  logic [CTX_W-1:0] ctx_i = '0;
  logic [63:0]      cia_i = '0, msr_i = '0, srr0_i = '0, srr1_i = '0;
  logic [63:0]      srr0_o, srr1_o, msr_o, nia_o;
  logic             srr0_vld_o, srr1_vld_o, msr_vld_o, nia_vld_o;
  logic [CTX_W-1:0] ctx_o;

  trap_unit #(.CTX_W(CTX_W)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int bi(int pos); return 63 - pos; endfunction
  function automatic bit rsv(int p); return (p >= 33 && p <= 36) || (p >= 42 && p <= 47); endfunction

  function automatic logic [63:0] ref_srr1(logic [63:0] cur);
    logic [63:0] r;
    for (int p = 0; p < 64; p++) r[bi(p)] = rsv(p) ? 1'b0 : cur[bi(p)];
    return r;
  endfunction

  function automatic logic [63:0] ref_msr(logic [63:0] cur, logic [63:0] s1);
    logic [63:0] r;
    for (int p = 0; p < 64; p++) begin
      if (p == 3)                         r[bi(p)] = s1[bi(p)] & cur[bi(p)];
      else if (p == 48 || p == 58 || p == 59) r[bi(p)] = s1[bi(p)] | s1[bi(49)];
      else if (p == 51)                   r[bi(p)] = cur[bi(3)] ? s1[bi(p)] : cur[bi(p)];
      else if (rsv(p))                    r[bi(p)] = 1'b0;
      else                                r[bi(p)] = s1[bi(p)];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h (op=%b)", req, got, exp, op_i);
    end
  endtask

  task automatic compare();
    logic [63:0] em;
    logic [3:0] ev;
    em = ref_msr(msr_i, srr1_i);
    ev = (op_i == 2'b01) ? 4'b1100 : (op_i == 2'b10) ? 4'b0011 : 4'b0000;
    chk("R1", {60'd0, srr0_vld_o, srr1_vld_o, msr_vld_o, nia_vld_o}, {60'd0, ev});
    chk("R2", srr0_o, cia_i + 64'd4);
    chk("R3", srr1_o & 64'h0000_0000_7830_0000 | srr1_o & 64'h0000_0000_003F_0000, 64'd0);
    chk("R4", srr1_o, ref_srr1(msr_i));
    chk("R5", {63'd0, msr_o[bi(3)]}, {63'd0, em[bi(3)]});
    chk("R6", {61'd0, msr_o[bi(48)], msr_o[bi(58)], msr_o[bi(59)]},
              {61'd0, em[bi(48)], em[bi(58)], em[bi(59)]});
    chk("R7", msr_o, em);
    chk("R8", {63'd0, msr_o[bi(51)]}, {63'd0, em[bi(51)]});
    chk("R9", {61'd0, msr_o[bi(29)], msr_o[bi(30)], msr_o[bi(31)]},
              {61'd0, srr1_i[bi(29)], srr1_i[bi(30)], srr1_i[bi(31)]});
    chk("R10", msr_o & 64'h0000_0000_783F_0000, 64'd0);
    chk("R11", nia_o, {srr0_i[63:2], 2'b00});
    chk("R12", {62'd0, ctx_o}, {62'd0, ctx_i});
  endtask

  task automatic apply(logic [1:0] op, logic [63:0] cia, logic [63:0] msr,
                       logic [63:0] s0, logic [63:0] s1, logic [CTX_W-1:0] ctx);
    @(posedge clk);
    op_i = op; cia_i = cia; msr_i = msr; srr0_i = s0; srr1_i = s1; ctx_i = ctx;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    compare();  // reset state: idle, no valids (R1)
    rst_ni = 1'b1;
    // R2 wrap, R3/R4 all ones
    apply(2'b01, 64'hFFFF_FFFF_FFFF_FFFC, '1, '0, '0, 2'd1);
    apply(2'b01, 64'hFFFF_FFFF_FFFF_FFFE, 64'hA5A5_5A5A_0F0F_F0F0, '1, '1, 2'd2);
    // R5/R8 all hypervisor combinations, R6 problem state on/off
    for (int k = 0; k < 16; k++) begin
      logic [63:0] m, s;
      m = '0; s = '0;
      m[bi(3)] = k[0]; s[bi(3)] = k[1]; s[bi(49)] = k[2];
      m[bi(51)] = k[3]; s[bi(51)] = ~k[3];
      apply(2'b10, '0, m, 64'h1234_5678_9ABC_DEF3, s, CTX_W'(k));
    end
    // R9 special transaction-state codes in current msr
    for (int t = 0; t < 8; t++) begin
      logic [63:0] m, s;
      m = '0; s = '1;
      {m[bi(29)], m[bi(30)], m[bi(31)]} = 3'(t);
      {s[bi(29)], s[bi(30)], s[bi(31)]} = 3'(7 - t);
      apply(2'b10, '0, m, 64'hFFFF_FFFF_FFFF_FFFF, s, 2'd3);
    end
    // R1 idle codes
    apply(2'b00, '1, '1, '1, '1, 2'd0);
    apply(2'b11, '1, '1, '1, '1, 2'd1);
    for (int i = 0; i < 400; i++)
      apply(2'($urandom()), rnd64(), rnd64(), rnd64(), rnd64(), CTX_W'($urandom()));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule